// File: doc/BRIEF.md
# Slotted Streaming I/O Bar

A streaming channel crosses a row of resource slots, starting at an input side and ending at an output side. Each slot owns one register stage on the bar and a one-bit mode. In pass-through mode the stage copies the word arriving from upstream. In tap mode the slot's module sees the arriving word on a read port and, in the same cycle, returns a replacement word on a write port. The stage then forwards that replacement downstream. When several slots are in tap mode, their modules transform the stream one after another, in slot order, and the traffic does not stop.

Every word travels with a valid bit. Because each slot always adds exactly one register, the time from input to output is SLOTS cycles whatever the mode pattern is. Modes are written one slot at a time through a small configuration port. A write takes effect at the next clock edge. The slot being switched forwards the upstream word during the write cycle, so no word is dropped or duplicated.

Top module: `stream_bar`

## Requirements
- R1: While reset is asserted, every slot is in pass-through mode (mode_state all zeros) and out_valid is 0.
- R2: A slot in pass-through mode loads, at each clock edge, the data and valid it receives from upstream, without modification.
- R3: A slot in tap mode loads, at each clock edge, its module's mod_data and mod_valid slice. A module that drives mod_valid low removes the word from the stream.
- R4: Slot i presents on tap_data/tap_valid slice i the word and valid it receives from upstream, whatever its mode. Slot 0 receives in_data/in_valid; slot i>0 receives the register of slot i-1.
- R5: With every slot in pass-through mode, a word presented at the input appears at the output exactly SLOTS clock edges later.
- R6: When several slots are in tap mode, the output word is the result of applying their modules in increasing slot order.
- R7: A cycle with cfg_we high sets mode_state bit cfg_slot to cfg_connect (1 = tap, 0 = pass-through) from the next clock edge on. Other slots keep their modes.
- R8: In a cycle where a write changes a slot's mode, that slot forwards its upstream word and valid unchanged. The first word under the new mode is the one that arrives in the next cycle.
- R9: Mode changes at any slot, in any cycle, leave the words passing through the other slots intact, and the stream is never stalled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | WIDTH | Stream word entering the first slot |
| in_valid | input | 1 | Qualifier for in_data |
| out_data | output | WIDTH | Stream word leaving the last slot |
| out_valid | output | 1 | Qualifier for out_data |
| tap_data | output | SLOTS*WIDTH | Read port: upstream word seen by each slot (slice i = slot i) |
| tap_valid | output | SLOTS | Read port valid for each slot |
| mod_data | input | SLOTS*WIDTH | Write port: replacement word from each slot's module |
| mod_valid | input | SLOTS | Write port valid from each module |
| cfg_we | input | 1 | Mode write strobe |
| cfg_slot | input | SLOT_IDX_W | Index of the slot being written |
| cfg_connect | input | 1 | New mode: 1 tap, 0 pass-through |
| mode_state | output | SLOTS | Current mode of each slot |

## Verification
A stage that loads the wrong source shows up at the output SLOTS-minus-index cycles later, and at the next slot's tap port one cycle later. A lost or extra valid bit therefore reaches the ports within at most SLOTS cycles. A mode register that holds a wrong value shows on mode_state at the edge after the write. It also shows in the data of the next word that passes through that slot. A wrong choice in the switch cycle corrupts exactly one word, and the per-cycle reference comparison catches that word at the output.

// File: rtl/stream_bar_pkg.sv
package stream_bar_pkg;

  typedef enum logic {
    MODE_PASS = 1'b0,
    MODE_TAP  = 1'b1
  } slot_mode_e;

  // A write that leaves the mode unchanged is not a switch.
  function automatic logic mode_switching(input logic hit, input logic new_mode,
                                          input logic cur_mode);
    return hit && (new_mode != cur_mode);
  endfunction

  // The module's word is taken only in a settled tap mode.
  function automatic logic take_module(input logic cur_mode, input logic switching);
    return (cur_mode == MODE_TAP) && !switching;
  endfunction

endpackage

// File: rtl/bar_slot_mode.sv
module bar_slot_mode
  import stream_bar_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_hit,
  input  logic wr_val,
  output logic mode_q,
  output logic switch_now
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_PASS;
    else if (wr_hit) mode_q <= wr_val;
  end

  assign switch_now = mode_switching(wr_hit, wr_val, mode_q);

  // R7
  mode_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (mode_q == $past(wr_val)));

  // R7
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(mode_q));

endmodule

// File: rtl/bar_slot_stage.sv
module bar_slot_stage #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] up_data,
  input  logic             up_valid,
  input  logic [WIDTH-1:0] mod_data,
  input  logic             mod_valid,
  input  logic             take_mod,
  output logic [WIDTH-1:0] q_data,
  output logic             q_valid
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_data  <= '0;
      q_valid <= 1'b0;
    end else if (take_mod) begin
      q_data  <= mod_data;
      q_valid <= mod_valid;
    end else begin
      q_data  <= up_data;
      q_valid <= up_valid;
    end
  end

  // R2
  pass_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take_mod |=> (q_valid == $past(up_valid)) && (q_data == $past(up_data)));

  // R3
  tap_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_mod |=> (q_valid == $past(mod_valid)) && (q_data == $past(mod_data)));

endmodule

// File: rtl/stream_bar.sv
module stream_bar
  import stream_bar_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int WIDTH = 8,
  localparam int SLOT_IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [WIDTH-1:0]       in_data,
  input  logic                   in_valid,
  output logic [WIDTH-1:0]       out_data,
  output logic                   out_valid,
  output logic [SLOTS*WIDTH-1:0] tap_data,
  output logic [SLOTS-1:0]       tap_valid,
  input  logic [SLOTS*WIDTH-1:0] mod_data,
  input  logic [SLOTS-1:0]       mod_valid,
  input  logic                   cfg_we,
  input  logic [SLOT_IDX_W-1:0]  cfg_slot,
  input  logic                   cfg_connect,
  output logic [SLOTS-1:0]       mode_state
);

  logic [WIDTH-1:0] seg_data [SLOTS+1];
  logic             seg_valid[SLOTS+1];
  logic [SLOTS-1:0] wr_hit;
  logic [SLOTS-1:0] switching;
  logic [SLOTS-1:0] take_mod;

  assign seg_data[0]  = in_data;
  assign seg_valid[0] = in_valid;

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    assign wr_hit[i]   = cfg_we && (cfg_slot == SLOT_IDX_W'(i));
    assign take_mod[i] = take_module(mode_state[i], switching[i]);

    bar_slot_mode u_mode (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_hit     (wr_hit[i]),
      .wr_val     (cfg_connect),
      .mode_q     (mode_state[i]),
      .switch_now (switching[i])
    );

    bar_slot_stage #(.WIDTH(WIDTH)) u_stage (
      .clk       (clk),
      .rst_n     (rst_n),
      .up_data   (seg_data[i]),
      .up_valid  (seg_valid[i]),
      .mod_data  (mod_data[i*WIDTH +: WIDTH]),
      .mod_valid (mod_valid[i]),
      .take_mod  (take_mod[i]),
      .q_data    (seg_data[i+1]),
      .q_valid   (seg_valid[i+1])
    );

    assign tap_data[i*WIDTH +: WIDTH] = seg_data[i];
    assign tap_valid[i]               = seg_valid[i];

    // R8
    switch_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_state[i] != $past(mode_state[i])) |->
        (seg_valid[i+1] == $past(seg_valid[i])) && (seg_data[i+1] == $past(seg_data[i])));
  end

  assign out_data  = seg_data[SLOTS];
  assign out_valid = seg_valid[SLOTS];

  // R1
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reset_state_chk: assert (mode_state == '0 && !out_valid);
    end
  end

endmodule

// File: tb/stream_bar_tb_top.sv
module stream_bar_tb_top;
  localparam int S  = 4;
  localparam int W  = 8;
  localparam int SW = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic           rst_n;
  logic [W-1:0]   in_data;
  logic           in_valid;
  logic [W-1:0]   out_data;
  logic           out_valid;
  logic [S*W-1:0] tap_data;
  logic [S-1:0]   tap_valid;
  logic [S*W-1:0] mod_data;
  logic [S-1:0]   mod_valid;
  logic           cfg_we;
  logic [SW-1:0]  cfg_slot;
  logic           cfg_connect;
  logic [S-1:0]   mode_state;
  logic [S-1:0]   kill;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  stream_bar #(.SLOTS(S), .WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .out_data(out_data), .out_valid(out_valid), .tap_data(tap_data),
    .tap_valid(tap_valid), .mod_data(mod_data), .mod_valid(mod_valid),
    .cfg_we(cfg_we), .cfg_slot(cfg_slot), .cfg_connect(cfg_connect),
    .mode_state(mode_state)
  );

  function automatic logic [W-1:0] key(input int i);
    return W'((i + 1) * 29);
  endfunction

  // Attached modules: each one XORs its own key onto the word it reads.
  for (genvar i = 0; i < S; i++) begin : g_mod
    assign mod_data[i*W +: W] = tap_data[i*W +: W] ^ key(i);
    assign mod_valid[i]       = tap_valid[i] & ~kill[i];
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference: the word held after each slot, plus the slot modes.
  logic [W-1:0] ref_d[S];
  logic         ref_v[S];
  logic         ref_m[S];

  initial for (int i = 0; i < S; i++) begin ref_d[i] = '0; ref_v[i] = 0; ref_m[i] = 0; end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < S; i++) begin ref_d[i] = '0; ref_v[i] = 0; ref_m[i] = 0; end
    end else begin
      for (int i = S - 1; i >= 0; i--) begin
        logic [W-1:0] ud;
        logic uv, changing;
        ud = (i == 0) ? in_data  : ref_d[i-1];
        uv = (i == 0) ? in_valid : ref_v[i-1];
        changing = cfg_we && (int'(cfg_slot) == i) && (cfg_connect != ref_m[i]);
        if (ref_m[i] && !changing) begin
          ref_d[i] = ud ^ key(i);
          ref_v[i] = uv & ~kill[i];
        end else begin
          ref_d[i] = ud;
          ref_v[i] = uv;
        end
        if (cfg_we && int'(cfg_slot) == i) ref_m[i] = cfg_connect;
      end
    end
  end

  // Per-cycle comparison, 1 ns after the falling edge.
  always @(negedge clk) begin
    #1;
    if (rst_n && !finished) begin
      chk("R9 out_valid", out_valid, ref_v[S-1]);
      chk("R9 out_data", out_data, ref_d[S-1]);
      for (int i = 0; i < S; i++) begin
        chk("R7 mode_state", mode_state[i], ref_m[i]);
        chk("R4 tap_valid", tap_valid[i], (i == 0) ? in_valid : ref_v[i-1]);
        chk("R4 tap_data", tap_data[i*W +: W], (i == 0) ? in_data : ref_d[i-1]);
      end
    end
  end

  task automatic write_mode(input int slot, input logic val);
    @(negedge clk);
    cfg_we = 1; cfg_slot = SW'(slot); cfg_connect = val;
    @(negedge clk);
    cfg_we = 0;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; in_data = '0; in_valid = 0; cfg_we = 0; cfg_slot = '0;
    cfg_connect = 0; kill = '0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 out_valid in reset", out_valid, 0);
    chk("R1 modes in reset", mode_state, 0);
    @(negedge clk);
    rst_n = 1;

    // R5 / R2: latency of SLOTS edges with all slots in pass-through
    @(negedge clk);
    in_data = 8'hA5; in_valid = 1;
    for (int k = 1; k <= S; k++) begin
      @(negedge clk);
      in_valid = 0;
      #1;
      chk("R5 latency out_valid", out_valid, (k == S));
      if (k == S) chk("R2 unchanged word", out_data, 8'hA5);
    end

    // R3: tap slot 1
    write_mode(1, 1);
    in_data = 8'h3C; in_valid = 1;
    for (int k = 1; k <= S; k++) begin
      @(negedge clk);
      in_valid = 0;
      #1;
      if (k == S) begin
        chk("R3 tapped valid", out_valid, 1);
        chk("R3 tapped word", out_data, 8'h3C ^ key(1));
      end
    end

    // R6: taps at slots 1 and 3 act in series
    write_mode(3, 1);
    in_data = 8'h81; in_valid = 1;
    for (int k = 1; k <= S; k++) begin
      @(negedge clk);
      in_valid = 0;
      #1;
      if (k == S) chk("R6 chained word", out_data, 8'h81 ^ key(1) ^ key(3));
    end

    // R8: switch slot 0 while a word passes through it
    @(negedge clk);
    cfg_we = 1; cfg_slot = 0; cfg_connect = 1;
    in_data = 8'h5A; in_valid = 1;
    @(negedge clk);
    cfg_we = 0;
    in_data = 8'h6B; in_valid = 1;
    for (int k = 2; k <= S + 1; k++) begin
      @(negedge clk);
      in_valid = 0;
      #1;
      if (k == S) chk("R8 switch-cycle word", out_data, 8'h5A ^ key(1) ^ key(3));
      if (k == S + 1) chk("R8 first tapped word", out_data, 8'h6B ^ key(0) ^ key(1) ^ key(3));
    end

    // R3: module drops the word by driving its valid low
    kill = 4'b0010;
    @(negedge clk);
    in_data = 8'h77; in_valid = 1;
    for (int k = 1; k <= S; k++) begin
      @(negedge clk);
      in_valid = 0;
      #1;
      if (k == S) chk("R3 dropped valid", out_valid, 0);
    end
    kill = '0;

    // R9: random continuous stream with random mode writes
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      in_data  = W'($urandom);
      in_valid = ($urandom % 4) != 0;
      cfg_we   = ($urandom % 5) == 0;
      cfg_slot = SW'($urandom);
      cfg_connect = $urandom % 2;
      kill = (($urandom % 8) == 0) ? S'($urandom) : '0;
    end
    @(negedge clk);
    cfg_we = 0; in_valid = 0; kill = '0;
    repeat (S + 2) @(negedge clk);
    #2;
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule